// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block implements a configuration register space reached through a pair of I/O ports: an index port at a fixed base address and a data port at the next address. After reset the space is locked. While locked, the index port only watches for a four-byte unlock key, and the data port reads as 0xFF. Once the key is accepted, software selects a register through the index port and reads or writes it through the data port. Writing the exit code to the exit register locks the space again.

The unlocked space holds the following registers:
- read-only chip identification and version bytes;
- a logical-device selector;
- a global flash control register, whose bits drive a suspend flag, three flash address-segment enables, a host-write enable and a flash pin selector;
- a pair of banked registers that exist only under the flash logical device and hold the serial-flash I/O base address.

The control bits and the aligned base address are brought out as ports for the logic that decodes flash cycles. The last key byte depends on the base port the block is built for. The base port, the chip ID and the version byte are parameters.

Top module: `cfgport_ctrl`

## Requirements
- R1: After reset the block is locked, the device selector is 0x00, the flash control register is 0x00, and the flash base output is 0x0000.
- R2: The block unlocks when the index port receives 0x87, 0x01 and 0x55 in that order, followed by a fourth byte. The fourth byte is 0x55 when BASE_PORT is 0x2E and 0xAA when BASE_PORT is 0x4E. Any other fourth byte leaves the block locked.
- R3: A key byte that does not match the expected one restarts the key. If that byte is itself 0x87, it counts as the first key byte.
- R4: While locked, a write to the data port changes nothing, and reads of both the index port and the data port return 0xFF. The flash outputs hold their values.
- R5: The index port sits at BASE_PORT and the data port at BASE_PORT+1. While unlocked, a read of the index port returns the last index written. A read of the data port returns the register that index selects. A read of any other address returns 0x00, and a write to any other address is ignored.
- R6: Writing 0x02 to register 0x02 locks the block. Any other value written to register 0x02 has no effect. Register 0x02 reads as 0x00.
- R7: Registers 0x20 and 0x21 return the high and low bytes of CHIP_ID, and register 0x22 returns CHIP_VER. Writes to these three registers are ignored.
- R8: Register 0x07 is the logical-device selector and reads back all 8 bits as written.
- R9: Register 0x24 drives the flash control outputs:
  - bit 0 drives flash_suspend;
  - bits 1 to 3 drive flash_seg_en[0] to flash_seg_en[2];
  - bit 4 drives flash_host_wr_en;
  - bit 5 drives flash_pin_sel;
  - bits 6 and 7 read as 0.
- R10: Registers 0x64 and 0x65 exist only while the device selector holds 0x07:
  - 0x64 stores its low nibble as base bits 11:8 and reads back with the upper nibble zero;
  - 0x65 stores bits 7:3 as base bits 7:3 and reads back with bits 2:0 forced to zero;
  - under any other device they read 0x00 and writes to them are ignored.
- R11: Any other register index reads 0x00, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | ADDR_W | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational from io_addr and state |
| cfg_open | output | 1 | High while the configuration space is unlocked |
| flash_base | output | ADDR_W | Serial-flash I/O base address, low three bits zero |
| flash_suspend | output | 1 | Suspend flag from the flash control register |
| flash_seg_en | output | 3 | Flash address-segment enables |
| flash_host_wr_en | output | 1 | Host write enable for flash |
| flash_pin_sel | output | 1 | Flash pin selector |

## Verification
The assertions assume that io_wr is a single-cycle strobe and that io_addr and io_wdata are stable while it is high. The bench drives every transaction one cycle at a time from negative edges to satisfy this. The assertions also assume that the decoded ports are the only route to state change, so the bench mixes writes to undecoded addresses and to the other instance's ports into its traffic. The read data is taken as combinational from the current address, and the bench samples it one time unit after changing the address, away from any edge.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  localparam logic [7:0] KEY_B0       = 8'h87;
  localparam logic [7:0] KEY_B1       = 8'h01;
  localparam logic [7:0] KEY_B2       = 8'h55;
  localparam logic [7:0] KEY_END_2E   = 8'h55;
  localparam logic [7:0] KEY_END_4E   = 8'hAA;

  localparam logic [7:0] RA_EXIT      = 8'h02;
  localparam logic [7:0] RA_DEVSEL    = 8'h07;
  localparam logic [7:0] RA_ID_HI     = 8'h20;
  localparam logic [7:0] RA_ID_LO     = 8'h21;
  localparam logic [7:0] RA_VER       = 8'h22;
  localparam logic [7:0] RA_FCTL      = 8'h24;
  localparam logic [7:0] RA_FBASE_HI  = 8'h64;
  localparam logic [7:0] RA_FBASE_LO  = 8'h65;

  localparam logic [7:0] EXIT_CODE    = 8'h02;
  localparam logic [7:0] DEV_FLASH    = 8'h07;
  localparam logic [7:0] LOCKED_READ  = 8'hFF;
  localparam logic [7:0] EMPTY_READ   = 8'h00;

  localparam int FCTL_W   = 6;
  localparam int FB_HI_W  = 4;
  localparam int FB_LO_W  = 5;
  localparam int FB_ALIGN = 3;

  typedef enum logic [1:0] {
    KP_NONE  = 2'd0,
    KP_ONE   = 2'd1,
    KP_TWO   = 2'd2,
    KP_THREE = 2'd3
  } key_prog_t;

  function automatic logic [7:0] final_key(input int base_port);
    return (base_port == 'h4E) ? KEY_END_4E : KEY_END_2E;
  endfunction

endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode #(
  parameter int ADDR_W    = 16,
  parameter int BASE_PORT = 'h2E
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              open,
  output logic              idx_hit,
  output logic              dat_hit,
  output logic              key_wr,
  output logic              idx_we,
  output logic              dat_we
);
  localparam logic [ADDR_W-1:0] IDX_ADDR = ADDR_W'(BASE_PORT);
  localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(BASE_PORT + 1);

  always_comb begin
    idx_hit = (addr == IDX_ADDR);
    dat_hit = (addr == DAT_ADDR);
    key_wr  = wr && idx_hit && !open;
    idx_we  = wr && idx_hit && open;
    dat_we  = wr && dat_hit && open;
  end
endmodule

// File: rtl/cfgp_unlock.sv
module cfgp_unlock
  import cfgp_pkg::*;
#(
  parameter logic [7:0] LAST_KEY = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  input  logic       exit_req,
  output logic       unlocked
);
  key_prog_t  prog_q, prog_d;
  logic       open_q, open_d;
  logic [7:0] expect_byte;
  logic       step_en;

  always_comb begin
    unique case (prog_q)
      KP_NONE:  expect_byte = KEY_B0;
      KP_ONE:   expect_byte = KEY_B1;
      KP_TWO:   expect_byte = KEY_B2;
      default:  expect_byte = LAST_KEY;
    endcase
  end

  always_comb begin
    prog_d  = prog_q;
    open_d  = open_q;
    step_en = 1'b0;
    if (open_q) begin
      if (exit_req) begin
        open_d  = 1'b0;
        prog_d  = KP_NONE;
        step_en = 1'b1;
      end
    end else if (key_wr) begin
      step_en = 1'b1;
      if (key_byte == expect_byte) begin
        if (prog_q == KP_THREE) begin
          open_d = 1'b1;
          prog_d = KP_NONE;
        end else begin
          prog_d = key_prog_t'(prog_q + 2'd1);
        end
      end else if (key_byte == KEY_B0) begin
        prog_d = KP_ONE;
      end else begin
        prog_d = KP_NONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= KP_NONE;
      open_q <= 1'b0;
    end else if (step_en) begin
      prog_q <= prog_d;
      open_q <= open_d;
    end
  end

  assign unlocked = open_q;
endmodule

// File: rtl/cfgp_regbank.sv
module cfgp_regbank
  import cfgp_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'hC3A5,
  parameter logic [7:0]  CHIP_VER = 8'h01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idx_we,
  input  logic               dat_we,
  input  logic [7:0]         wdata,
  output logic [7:0]         idx_q,
  output logic               exit_req,
  output logic [7:0]         rd_val,
  output logic [FCTL_W-1:0]  fctl_q,
  output logic [FB_HI_W-1:0] fb_hi_q,
  output logic [FB_LO_W-1:0] fb_lo_q
);
  logic [7:0]         devsel_q, devsel_d;
  logic [7:0]         idx_d;
  logic [FCTL_W-1:0]  fctl_d;
  logic [FB_HI_W-1:0] fb_hi_d;
  logic [FB_LO_W-1:0] fb_lo_d;
  logic               flash_dev;
  logic               devsel_en, fctl_en, fb_hi_en, fb_lo_en;

  always_comb begin
    flash_dev = (devsel_q == DEV_FLASH);
    devsel_en = dat_we && (idx_q == RA_DEVSEL);
    fctl_en   = dat_we && (idx_q == RA_FCTL);
    fb_hi_en  = dat_we && flash_dev && (idx_q == RA_FBASE_HI);
    fb_lo_en  = dat_we && flash_dev && (idx_q == RA_FBASE_LO);
    exit_req  = dat_we && (idx_q == RA_EXIT) && (wdata == EXIT_CODE);
    idx_d     = wdata;
    devsel_d  = wdata;
    fctl_d    = wdata[FCTL_W-1:0];
    fb_hi_d   = wdata[FB_HI_W-1:0];
    fb_lo_d   = wdata[7:FB_ALIGN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      devsel_q <= '0;
      fctl_q   <= '0;
      fb_hi_q  <= '0;
      fb_lo_q  <= '0;
    end else begin
      if (idx_we)    idx_q    <= idx_d;
      if (devsel_en) devsel_q <= devsel_d;
      if (fctl_en)   fctl_q   <= fctl_d;
      if (fb_hi_en)  fb_hi_q  <= fb_hi_d;
      if (fb_lo_en)  fb_lo_q  <= fb_lo_d;
    end
  end

  always_comb begin
    unique case (idx_q)
      RA_DEVSEL:   rd_val = devsel_q;
      RA_ID_HI:    rd_val = CHIP_ID[15:8];
      RA_ID_LO:    rd_val = CHIP_ID[7:0];
      RA_VER:      rd_val = CHIP_VER;
      RA_FCTL:     rd_val = {{(8-FCTL_W){1'b0}}, fctl_q};
      RA_FBASE_HI: rd_val = flash_dev ? {{(8-FB_HI_W){1'b0}}, fb_hi_q} : EMPTY_READ;
      RA_FBASE_LO: rd_val = flash_dev ? {fb_lo_q, {FB_ALIGN{1'b0}}} : EMPTY_READ;
      default:     rd_val = EMPTY_READ;
    endcase
  end
endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
  import cfgp_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          BASE_PORT = 'h2E,
  parameter logic [15:0] CHIP_ID   = 16'hC3A5,
  parameter logic [7:0]  CHIP_VER  = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              cfg_open,
  output logic [ADDR_W-1:0] flash_base,
  output logic              flash_suspend,
  output logic [2:0]        flash_seg_en,
  output logic              flash_host_wr_en,
  output logic              flash_pin_sel
);
  localparam logic [7:0] LAST_KEY = final_key(BASE_PORT);
  localparam int         BASE_PAD = ADDR_W - (FB_HI_W + FB_LO_W + FB_ALIGN);

  logic               idx_hit, dat_hit, key_wr, idx_we, dat_we;
  logic               exit_req, open;
  logic [7:0]         idx_q, rd_val;
  logic [FCTL_W-1:0]  fctl_q;
  logic [FB_HI_W-1:0] fb_hi_q;
  logic [FB_LO_W-1:0] fb_lo_q;

  cfgp_decode #(.ADDR_W(ADDR_W), .BASE_PORT(BASE_PORT)) u_decode (
    .addr(io_addr), .wr(io_wr), .open(open),
    .idx_hit(idx_hit), .dat_hit(dat_hit),
    .key_wr(key_wr), .idx_we(idx_we), .dat_we(dat_we)
  );

  cfgp_unlock #(.LAST_KEY(LAST_KEY)) u_unlock (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_byte(io_wdata),
    .exit_req(exit_req), .unlocked(open)
  );

  cfgp_regbank #(.CHIP_ID(CHIP_ID), .CHIP_VER(CHIP_VER)) u_regs (
    .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .dat_we(dat_we),
    .wdata(io_wdata), .idx_q(idx_q), .exit_req(exit_req), .rd_val(rd_val),
    .fctl_q(fctl_q), .fb_hi_q(fb_hi_q), .fb_lo_q(fb_lo_q)
  );

  always_comb begin
    if (idx_hit)      io_rdata = open ? idx_q  : LOCKED_READ;
    else if (dat_hit) io_rdata = open ? rd_val : LOCKED_READ;
    else              io_rdata = EMPTY_READ;
  end

  generate
    if (BASE_PAD > 0) begin : g_pad
      assign flash_base = {{BASE_PAD{1'b0}}, fb_hi_q, fb_lo_q, {FB_ALIGN{1'b0}}};
    end else begin : g_nopad
      assign flash_base = {fb_hi_q, fb_lo_q, {FB_ALIGN{1'b0}}};
    end
  endgenerate

  assign cfg_open         = open;
  assign flash_suspend    = fctl_q[0];
  assign flash_seg_en     = fctl_q[3:1];
  assign flash_host_wr_en = fctl_q[4];
  assign flash_pin_sel    = fctl_q[5];
endmodule

// File: rtl/cfgport_ctrl_chk.sv
module cfgport_ctrl_chk #(
  parameter int ADDR_W    = 16,
  parameter int BASE_PORT = 'h2E
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_wr,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              cfg_open,
  input logic [ADDR_W-1:0] flash_base,
  input logic              flash_suspend,
  input logic [2:0]        flash_seg_en,
  input logic              flash_host_wr_en,
  input logic              flash_pin_sel
);
  localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(BASE_PORT);
  localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(BASE_PORT + 1);

  logic [7:0] seen_idx;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 seen_idx <= 8'h00;
    else if (io_wr && io_addr == IDX_A && cfg_open) seen_idx <= io_wdata;
  end

  // R4: locked space reads 0xFF on the data port
  a_r4_locked_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && io_addr == DAT_A) |-> io_rdata == 8'hFF);

  // R4: nothing in the flash outputs moves while locked
  a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(flash_base) && $stable(flash_seg_en) &&
                   $stable(flash_suspend) && $stable(flash_host_wr_en) &&
                   $stable(flash_pin_sel)));

  // R2: only an index-port write can open the space
  a_r2_open_via_index: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && !(io_wr && io_addr == IDX_A)) |=> !cfg_open);

  // R6: exit code to the exit register relocks
  a_r6_exit_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_wr && io_addr == DAT_A && seen_idx == 8'h02 &&
     io_wdata == 8'h02) |=> !cfg_open);

  // R10: base address is aligned and below 0x1000
  a_r10_base_align: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_base[2:0] == 3'b000) && (flash_base >> 12) == '0);
endmodule

bind cfgport_ctrl cfgport_ctrl_chk #(.ADDR_W(ADDR_W), .BASE_PORT(BASE_PORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open),
  .flash_base(flash_base), .flash_suspend(flash_suspend),
  .flash_seg_en(flash_seg_en), .flash_host_wr_en(flash_host_wr_en),
  .flash_pin_sel(flash_pin_sel)
);

// File: tb/tb_cfgport_ctrl.sv
module tb_cfgport_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CID = 'hC3A5;
  localparam int CVER = 'h01;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_wr;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata, alt_rdata;
  logic        cfg_open, alt_open;
  logic [15:0] flash_base, alt_base;
  logic        flash_suspend, flash_host_wr_en, flash_pin_sel;
  logic [2:0]  flash_seg_en;
  logic        alt_susp, alt_hwe, alt_pin;
  logic [2:0]  alt_seg;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  bit cmp_on  = 0;

  // reference model state
  int m_open, m_cnt, m_idx, m_dev, m_fctl, m_bhi, m_blo;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgport_ctrl #(.BASE_PORT('h2E), .CHIP_ID(16'hC3A5), .CHIP_VER(8'h01)) dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open),
    .flash_base(flash_base), .flash_suspend(flash_suspend),
    .flash_seg_en(flash_seg_en), .flash_host_wr_en(flash_host_wr_en),
    .flash_pin_sel(flash_pin_sel));

  cfgport_ctrl #(.BASE_PORT('h4E)) dut_alt (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(alt_rdata), .cfg_open(alt_open),
    .flash_base(alt_base), .flash_suspend(alt_susp),
    .flash_seg_en(alt_seg), .flash_host_wr_en(alt_hwe),
    .flash_pin_sel(alt_pin));

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int key_at(input int n);
    case (n)
      0: return 'h87;
      1: return 'h01;
      2: return 'h55;
      default: return 'h55;
    endcase
  endfunction

  function automatic int m_reg();
    case (m_idx)
      'h07: return m_dev;
      'h20: return CID >> 8;
      'h21: return CID & 'hFF;
      'h22: return CVER;
      'h24: return m_fctl;
      'h64: return (m_dev == 7) ? m_bhi : 0;
      'h65: return (m_dev == 7) ? m_blo : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int m_read(input int a);
    if (a == 'h2E) return m_open ? m_idx : 'hFF;
    if (a == 'h2F) return m_open ? m_reg() : 'hFF;
    return 0;
  endfunction

  task automatic m_write(input int a, input int d);
    if (a == 'h2E && !m_open) begin
      if (d == key_at(m_cnt)) begin
        if (m_cnt == 3) begin m_open = 1; m_cnt = 0; end
        else m_cnt++;
      end else m_cnt = (d == 'h87) ? 1 : 0;
    end else if (a == 'h2E) begin
      m_idx = d;
    end else if (a == 'h2F && m_open) begin
      case (m_idx)
        'h02: if (d == 2) begin m_open = 0; m_cnt = 0; end
        'h07: m_dev = d;
        'h24: m_fctl = d & 'h3F;
        'h64: if (m_dev == 7) m_bhi = d & 'h0F;
        'h65: if (m_dev == 7) m_blo = d & 'hF8;
        default: ;
      endcase
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = 16'(a); io_wdata = 8'(d);
    @(posedge clk);
    m_write(a, d);
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input int a);
    @(negedge clk);
    io_addr = 16'(a);
    #1;
    check(tag, int'(io_rdata), m_read(a));
  endtask

  task automatic key2e(input int last);
    wr('h2E, 'h87); wr('h2E, 'h01); wr('h2E, 'h55); wr('h2E, last);
  endtask

  // per-clock comparison of registered outputs against the model (R9, R10, R2)
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check("R2 open", int'(cfg_open), m_open);
      check("R10 base", int'(flash_base), (m_bhi << 8) | m_blo);
      check("R9 ctrl", int'({flash_pin_sel, flash_host_wr_en, flash_seg_en, flash_suspend}), m_fctl);
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_open = 0; m_cnt = 0; m_idx = 0; m_dev = 0; m_fctl = 0; m_bhi = 0; m_blo = 0;
    rst_n = 1'b0; io_wr = 1'b0; io_addr = 16'h0; io_wdata = 8'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    check("R1 locked", int'(cfg_open), 0);
    check("R1 base", int'(flash_base), 0);
    check("R1 ctrl", int'({flash_pin_sel, flash_host_wr_en, flash_seg_en, flash_suspend}), 0);
    cmp_on = 1;
    // R4 locked behaviour
    rd("R4 data locked", 'h2F);
    rd("R4 index locked", 'h2E);
    wr('h2F, 'h3F);
    rd("R4 data still ff", 'h2F);
    // R2 wrong last byte for 0x2E
    key2e('hAA);
    check("R2 aa rejected on 2e", int'(cfg_open), 0);
    // R3 restart on mismatch
    wr('h2E, 'h87); wr('h2E, 'h01); wr('h2E, 'h00); wr('h2E, 'h55); wr('h2E, 'h55);
    check("R3 restart", int'(cfg_open), 0);
    wr('h2E, 'h87); wr('h2E, 'h87); wr('h2E, 'h01); wr('h2E, 'h55); wr('h2E, 'h55);
    check("R3 87 requalifies", int'(cfg_open), 1);
    // R5, R7
    wr('h2E, 'h20); rd("R7 id hi", 'h2F);
    wr('h2E, 'h21); rd("R7 id lo", 'h2F);
    wr('h2E, 'h22); rd("R7 version", 'h2F);
    wr('h2F, 'h99); rd("R7 write ignored", 'h2F);
    rd("R5 index readback", 'h2E);
    rd("R5 other address", 'h30);
    wr('h2D, 'h07);
    rd("R5 other write ignored", 'h2E);
    // R8, R10
    wr('h2E, 'h07); wr('h2F, 'h05); rd("R8 devsel", 'h2F);
    wr('h2E, 'h64); wr('h2F, 'h12); rd("R10 hidden bank", 'h2F);
    wr('h2E, 'h07); wr('h2F, 'h07);
    wr('h2E, 'h64); wr('h2F, 'hF3); rd("R10 base hi", 'h2F);
    wr('h2E, 'h65); wr('h2F, 'hFF); rd("R10 base lo", 'h2F);
    check("R10 base value", int'(flash_base), 'h03F8);
    // R9
    wr('h2E, 'h24); wr('h2F, 'hFF); rd("R9 fctl mask", 'h2F);
    wr('h2F, 'h15); rd("R9 fctl", 'h2F);
    check("R9 seg", int'(flash_seg_en), 'h2);
    check("R9 host wr", int'(flash_host_wr_en), 1);
    // R11
    wr('h2E, 'h30); wr('h2F, 'h55); rd("R11 unknown reg", 'h2F);
    // R6
    wr('h2E, 'h02); rd("R6 exit reads 0", 'h2F);
    wr('h2F, 'h01);
    check("R6 other value keeps open", int'(cfg_open), 1);
    wr('h2F, 'h02);
    check("R6 relocked", int'(cfg_open), 0);
    rd("R6 locked read", 'h2F);
    check("R6 ctrl retained", int'(flash_host_wr_en), 1);
    // R2 alternate base port
    wr('h4E, 'h87); wr('h4E, 'h01); wr('h4E, 'h55); wr('h4E, 'h55);
    check("R2 55 rejected on 4e", int'(alt_open), 0);
    wr('h4E, 'h87); wr('h4E, 'h01); wr('h4E, 'h55); wr('h4E, 'hAA);
    check("R2 aa opens 4e", int'(alt_open), 1);
    check("R5 2e unaffected", int'(cfg_open), 0);
    // re-open and confirm retained state
    key2e('h55);
    wr('h2E, 'h07); rd("R8 devsel retained", 'h2F);
    wr('h2E, 'h65); rd("R10 base lo retained", 'h2F);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule